// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two W-bit words and reads the bit patterns under a format chosen per operation: two's complement, ones' complement, sign-magnitude, or plain unsigned. One XOR stage inverts the second operand for subtraction. Each format then uses its own addition rule. Two's complement and unsigned share the plain binary sum with a carry-in. Ones' complement feeds the carry-out back into the low end of the sum. Sign-magnitude compares the two signs and then either adds the magnitudes or subtracts the smaller magnitude from the larger.

Every operation gives four results: the W-bit result word, an unsigned carry/borrow flag for the raw bit patterns, a signed overflow flag for the selected encoding, and a zero flag that accepts every encoding of zero in that format. The results are registered once. The input side is a valid-only stream. The block takes one operation in every cycle that `in_valid` is high and never applies back-pressure, so there is no ready signal. `out_valid` is `in_valid` delayed by one cycle. The registered outputs keep their last value while no operation is presented.

Top module: `mfmt_addsub`

## Requirements
- R1: With `fmt` = 2'b00 (two's complement), `res` equals (a + b) mod 2^W when `sub` = 0 and (a - b) mod 2^W when `sub` = 1.
- R2: In every format, `cb` is the carry-out of the unsigned sum a + b when `sub` = 0. When `sub` = 1 it is the borrow, which is 1 exactly when a < b as unsigned numbers.
- R3: With `fmt` = 2'b00, `sovf` is 1 exactly when the true signed result lies outside -2^(W-1) .. 2^(W-1)-1. An add of two operands with different sign bits never sets it, and neither does the all-ones to all-zeros rollover.
- R4: With `fmt` = 2'b01 (ones' complement, where a negative value is the bitwise inverse of its magnitude), the sum is formed with end-around carry. `sovf` is 1 exactly when the true result lies outside -(2^(W-1)-1) .. 2^(W-1)-1. Otherwise `res` encodes the true result, and a zero result may use either zero pattern.
- R5: With `fmt` = 2'b10 (sign-magnitude, where the top bit is the sign and the low W-1 bits are the magnitude), `res` is the true result with the sign set only for negative values. `sovf` is 1 exactly when the result magnitude exceeds 2^(W-1)-1. In that case `res` is the sign of `a` followed by the magnitude sum mod 2^(W-1).
- R6: In sign-magnitude, a result with zero magnitude that is not an overflow is always returned as positive zero (all bits 0).
- R7: With `fmt` = 2'b11 (unsigned), `res` is the same as in R1 and `sovf` is always 0.
- R8: `zero` is 1 when `res` is a zero of the selected format. That is all-zeros in two's complement and unsigned, all-zeros or all-ones in ones' complement, and a zero magnitude with either sign in sign-magnitude.
- R9: `res`, `cb`, `sovf` and `zero` update one clock after a cycle with `in_valid` = 1 and hold their value after a cycle with `in_valid` = 0. `out_valid` equals `in_valid` of the previous cycle.
- R10: While `rst_n` is low, `out_valid`, `res`, `cb`, `sovf` and `zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sub | input | 1 | 0 = a + b, 1 = a - b |
| fmt | input | 2 | 00 two's, 01 ones', 10 sign-magnitude, 11 unsigned |
| out_valid | output | 1 | Registered result valid |
| res | output | WIDTH | Result word |
| cb | output | 1 | Unsigned carry (add) or borrow (subtract) |
| sovf | output | 1 | Signed overflow for the selected format |
| zero | output | 1 | Result is a zero of the selected format |

## Verification
The assertions assume that `fmt`, `sub` and the operands are known values in every cycle where `in_valid` is high. They also assume that a result is judged only one cycle after it is presented, because the result registers load on `in_valid` alone. The stimulus drives every field at the falling edge and keeps inputs fixed through the capturing edge. It covers every operand pair, both operations and all four formats at a width of 4. Any cycle with `in_valid` low also changes the operands, so that a result register which loads when it should hold shows up at the ports.

// File: rtl/mfmt_pkg.sv
package mfmt_pkg;

  typedef enum logic [1:0] {
    FMT_TWOS = 2'b00,
    FMT_ONES = 2'b01,
    FMT_SMAG = 2'b10,
    FMT_UNS  = 2'b11
  } fmt_e;

  // Same-sign operands whose sum has the opposite sign
  function automatic logic same_sign_flip(input logic s_x, input logic s_y, input logic s_r);
    return (s_x == s_y) && (s_r != s_x);
  endfunction

endpackage

// File: rtl/mfmt_binadd.sv
module mfmt_binadd #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             inv,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH:0]   wide;

  // controlled inverter: one XOR per bit
  assign y_eff = y ^ {WIDTH{inv}};
  assign wide  = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, cin};
  assign sum   = wide[WIDTH-1:0];
  assign cout  = wide[WIDTH];
endmodule

// File: rtl/mfmt_smag.sv
module mfmt_smag #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             ovf
);
  localparam int MW = WIDTH - 1;

  logic          s_x, s_y;
  logic [MW-1:0] m_x, m_y, m_sum, m_diff, m_out;
  logic          m_carry, x_ge, same, s_out;

  assign s_x = x[WIDTH-1];
  assign s_y = y[WIDTH-1] ^ sub;   // subtracting flips the sign of y
  assign m_x = x[MW-1:0];
  assign m_y = y[MW-1:0];

  assign {m_carry, m_sum} = {1'b0, m_x} + {1'b0, m_y};
  assign x_ge   = (m_x >= m_y);
  assign m_diff = x_ge ? (m_x - m_y) : (m_y - m_x);
  assign same   = (s_x == s_y);

  always_comb begin
    if (same) begin
      m_out = m_sum;
      s_out = s_x;
    end else begin
      m_out = m_diff;
      s_out = x_ge ? s_x : s_y;
    end
  end

  assign ovf = same & m_carry;
  // zero magnitude without overflow is reported as positive zero
  assign res = {s_out & ((|m_out) | ovf), m_out};
endmodule

// File: rtl/mfmt_addsub.sv
module mfmt_addsub
  import mfmt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic [1:0]       fmt,
  output logic             out_valid,
  output logic [WIDTH-1:0] res,
  output logic             cb,
  output logic             sovf,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  fmt_e fmt_sel;
  assign fmt_sel = fmt_e'(fmt);

  // binary path: two's complement, unsigned, carry/borrow
  logic [WIDTH-1:0] bin_sum;
  logic             bin_co;
  mfmt_binadd #(.WIDTH(WIDTH)) u_bin (
    .x(a), .y(b), .inv(sub), .cin(sub), .sum(bin_sum), .cout(bin_co)
  );

  // ones' complement path: raw sum, then end-around carry
  logic [WIDTH-1:0] raw_sum, eac_sum;
  logic             raw_co, eac_co;
  mfmt_binadd #(.WIDTH(WIDTH)) u_raw (
    .x(a), .y(b), .inv(sub), .cin(1'b0), .sum(raw_sum), .cout(raw_co)
  );
  mfmt_binadd #(.WIDTH(WIDTH)) u_eac (
    .x(raw_sum), .y('0), .inv(1'b0), .cin(raw_co), .sum(eac_sum), .cout(eac_co)
  );

  // sign-magnitude path
  logic [WIDTH-1:0] sm_res;
  logic             sm_ovf;
  mfmt_smag #(.WIDTH(WIDTH)) u_smag (
    .x(a), .y(b), .sub(sub), .res(sm_res), .ovf(sm_ovf)
  );

  logic             b_sign_eff;
  logic [WIDTH-1:0] nx_res;
  logic             nx_ovf, nx_zero, nx_cb;

  assign b_sign_eff = b[MSB] ^ sub;
  assign nx_cb      = sub ? ~bin_co : bin_co;

  always_comb begin
    unique case (fmt_sel)
      FMT_TWOS: begin
        nx_res  = bin_sum;
        nx_ovf  = same_sign_flip(a[MSB], b_sign_eff, bin_sum[MSB]);
        nx_zero = ~|bin_sum;
      end
      FMT_ONES: begin
        nx_res  = eac_sum;
        nx_ovf  = same_sign_flip(a[MSB], b_sign_eff, eac_sum[MSB]);
        nx_zero = (~|eac_sum) | (&eac_sum);
      end
      FMT_SMAG: begin
        nx_res  = sm_res;
        nx_ovf  = sm_ovf;
        nx_zero = ~|sm_res[MSB-1:0];
      end
      default: begin
        nx_res  = bin_sum;
        nx_ovf  = 1'b0;
        nx_zero = ~|bin_sum;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      cb        <= 1'b0;
      sovf      <= 1'b0;
      zero      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res  <= nx_res;
        cb   <= nx_cb;
        sovf <= nx_ovf;
        zero <= nx_zero;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res) && $stable(cb) && $stable(sovf) && $stable(zero)));
  // R3
  mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00 && !sub && (a[MSB] != b[MSB])) |=> !sovf);
  // R6
  pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b10) |=> (sovf || !(res[MSB] && ~|res[MSB-1:0])));
  // R7
  uns_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b11) |=> !sovf);
  // R8
  twos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00) |=> (zero == (res == '0)));
  // R2
  borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub && (a == b)) |=> !cb);
endmodule

// File: tb/sim_mfmt_addsub.sv
module sim_mfmt_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         sub = 1'b0;
  logic [1:0]   fmt = 2'b00;
  logic         out_valid, cb, sovf, zero;
  logic [W-1:0] res;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  mfmt_addsub #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .sub(sub),
    .fmt(fmt), .out_valid(out_valid), .res(res), .cb(cb), .sovf(sovf), .zero(zero)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int dec(input int v, input int f);
    if (f == 0) return (v >= HALF) ? v - SPAN : v;
    if (f == 1) return (v >= HALF) ? -((SPAN - 1) - v) : v;
    if (f == 2) return (v >= HALF) ? -(v - HALF) : v;
    return v;
  endfunction

  task automatic report(input string tag, input bit ok, input int got, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h sub=%0b fmt=%0d)",
               tag, got, exp, a, b, sub, fmt);
    end
  endtask

  task automatic run_one(input int ai, input int bi, input int s, input int f);
    int  t, e_res, mag;
    bit  e_ovf, e_cb, e_zero, any_zero_ok;
    @(negedge clk);
    in_valid = 1'b1; a = W'(ai); b = W'(bi); sub = s[0]; fmt = 2'(f);
    @(negedge clk);
    e_cb = (s != 0) ? (ai < bi) : ((ai + bi) >= SPAN);
    t = (s != 0) ? dec(ai, f) - dec(bi, f) : dec(ai, f) + dec(bi, f);
    any_zero_ok = 1'b0;
    e_res = ((s != 0) ? (ai - bi) : (ai + bi)) & (SPAN - 1);
    e_ovf = 1'b0;
    case (f)
      0: e_ovf = (t < -HALF) || (t > HALF - 1);
      1: begin
        e_ovf = (t < -(HALF - 1)) || (t > HALF - 1);
        if (!e_ovf) begin
          e_res = (t < 0) ? (SPAN - 1) + t : t;
          any_zero_ok = (t == 0);
        end
      end
      2: begin
        mag = (t < 0) ? -t : t;
        e_ovf = mag > HALF - 1;
        if (e_ovf) e_res = (ai & HALF) | (mag & (HALF - 1));
        else e_res = (t < 0) ? (HALF | mag) : mag;
      end
      default: ;
    endcase
    if (f == 1) e_zero = !e_ovf && (t == 0);
    else if (f == 2) e_zero = (e_res & (HALF - 1)) == 0;
    else e_zero = (e_res == 0);

    report("R9 out_valid", out_valid == 1'b1, out_valid, 1);
    report("R2 carry/borrow", cb == e_cb, cb, e_cb);
    if (f == 0) begin
      report("R1 two's result", res == W'(e_res), res, e_res);
      report("R3 two's overflow", sovf == e_ovf, sovf, e_ovf);
    end else if (f == 1) begin
      report("R4 ones' overflow", sovf == e_ovf, sovf, e_ovf);
      if (!e_ovf)
        report("R4 ones' result",
               any_zero_ok ? (res == '0 || res == '1) : (res == W'(e_res)), res, e_res);
    end else if (f == 2) begin
      report("R5 sign-magnitude overflow", sovf == e_ovf, sovf, e_ovf);
      report((t == 0) ? "R6 positive zero" : "R5 sign-magnitude result",
             res == W'(e_res), res, e_res);
    end else begin
      report("R7 unsigned result", res == W'(e_res), res, e_res);
      report("R7 unsigned no overflow", sovf == 1'b0, sovf, 0);
    end
    report("R8 zero flag", zero == e_zero, zero, e_zero);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    // R10 reset state
    #(CLK_PERIOD * 2 + 1);
    report("R10 reset out_valid", out_valid == 1'b0, out_valid, 0);
    report("R10 reset res", res == '0, res, 0);
    report("R10 reset flags", {cb, sovf, zero} == 3'b000, {cb, sovf, zero}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        for (int ai = 0; ai < SPAN; ai++)
          for (int bi = 0; bi < SPAN; bi++)
            run_one(ai, bi, s, f);

    // R3 named corners: rollover -1 + 1 and max + 1
    run_one(SPAN - 1, 1, 0, 0);
    report("R3 rollover not overflow", sovf == 1'b0, sovf, 0);
    run_one(HALF - 1, 1, 0, 0);
    report("R3 max plus one overflows", sovf == 1'b1, sovf, 1);

    // R9 hold with in_valid low while inputs change
    run_one(3, 2, 0, 3);
    held = res;
    @(negedge clk);
    in_valid = 1'b0; a = W'(9); b = W'(9); sub = 1'b1; fmt = 2'b01;
    @(negedge clk);
    report("R9 idle out_valid", out_valid == 1'b0, out_valid, 0);
    report("R9 idle hold res", res == held, res, held);
    report("R9 idle hold zero", zero == 1'b0, zero, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule